// File: doc/BRIEF.md
# Translation Context Pointer Register

This block holds a 64-bit pointer that a TLB refill handler uses to reach the page-table entry for a faulting address. Software owns the upper base bits and sets them to the start of its page-table array. When the MMU raises a refill, invalid or modified exception, hardware fills the lower fields from the faulting virtual address. Those fields are the two-bit address region and the faulting virtual page-pair number. After that update the register can be used as a pointer without further shifting.

The `layout_var` input selects one of two layouts. In the fixed layout the page-number window sits at bits SEGBITS-10 down to 4, and the region sits directly above it. In the variable layout the window is the single run of set bits in `cfg_mask`. The run spans bit X-1 down to bit Y. The region always occupies the two bits just above the window. Everything above the region belongs to software, and everything below the window reads as zero. A mask with bits 30..4 set reproduces the fixed layout when SEGBITS is 40. The block has no state machine. A single register updates on a software write, a qualifying exception, or both.

Top module: `ctx_pointer_reg`

## Requirements
- R1: After reset, `ctx_q` is all zeros.
- R2: In the fixed layout (`layout_var`=0), an exception with cause code 0 (refill), 1 (invalid) or 2 (modified) writes virtual-address bits SEGBITS-1..13 into `ctx_q` bits SEGBITS-10..4, which is bits 30..4 for SEGBITS=40.
- R3: A qualifying exception writes virtual-address bits 63..62 into the region field. In the fixed layout that field is bits 32..31 (SEGBITS=40). In the variable layout it is bits X+1..X.
- R4: A software write replaces only the base bits: 63..SEGBITS-7 in the fixed layout, and 63..X+2 in the variable layout. The region and page-number bits keep their values.
- R5: After any software write or qualifying exception, every bit below the page-number window reads zero. In the fixed layout these are bits 3..0.
- R6: In the variable layout, with the window at X-1..Y and X-Y no larger than SEGBITS, an exception writes virtual-address bits SEGBITS-1..SEGBITS-(X-Y) into bits X-1..Y.
- R7: In the variable layout, a mask with exactly bits 30..4 set gives the same register value as the fixed layout for the same write and exception.
- R8: An exception with cause code 3 (address error), or any code from 4 to 7, leaves `ctx_q` unchanged.
- R9: When a software write and a qualifying exception occur in the same cycle, the base bits take the write data and the region and page-number bits take the exception values.
- R10: When COMPAT_ONLY=1, the region field receives {VA[63],VA[63]}, so only codes 00 and 11 appear.
- R11: In a cycle with no software write and no qualifying exception, `ctx_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 64 | Software write data (only base bits taken) |
| exc_valid | input | 1 | Exception strobe |
| exc_cause | input | 3 | Exception cause code: 0 refill, 1 invalid, 2 modified, 3 address error, 4..7 other |
| exc_vaddr | input | 64 | Faulting virtual address |
| layout_var | input | 1 | 0 = fixed layout, 1 = layout from `cfg_mask` |
| cfg_mask | input | 64 | Contiguous mask giving the page-number window |
| ctx_q | output | 64 | Register contents |

## Verification
The exception path is driven with several address patterns: all ones, alternating bits, a walking pattern, and values whose top two bits cover every region code. Together these show whether the page-number window is placed and sliced correctly and whether the region bits are taken from the right address bits. The variable layout is tried with narrow, mid-range and top-reaching windows; the top-reaching window leaves no base bits at all. These runs separate a correct shift from an off-by-one in X or Y. The same write and exception are also applied in the fixed layout and with the 30..4 mask, and the two results are compared directly. Address-error and other cause codes, idle cycles, and same-cycle write-plus-exception sequences show which fields each event may touch.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    localparam int REG_W = 64;
    localparam int POS_W = 8;

    typedef enum logic [2:0] {
        CAUSE_REFILL   = 3'd0,
        CAUSE_INVALID  = 3'd1,
        CAUSE_MODIFIED = 3'd2,
        CAUSE_ADDR_ERR = 3'd3
    } cause_e;

    // Ones in every bit position below n.
    function automatic logic [REG_W-1:0] low_ones(input logic [POS_W-1:0] n);
        logic [REG_W-1:0] r;
        if (n >= POS_W'(REG_W)) r = '1;
        else r = (REG_W'(1) << n) - REG_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/ctx_mask_decode.sv
module ctx_mask_decode
    import ctx_pkg::*;
#(
    parameter int WIDTH = REG_W
) (
    input  logic [WIDTH-1:0] mask,
    output logic [POS_W-1:0] top_x,
    output logic [POS_W-1:0] bot_y
);
    // top_x is one above the highest set bit; bot_y is the lowest set bit.
    always_comb begin
        top_x = '0;
        bot_y = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (mask[i]) top_x = POS_W'(i + 1);
        end
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (mask[i]) bot_y = POS_W'(i);
        end
    end
endmodule

// File: rtl/ctx_field_pack.sv
module ctx_field_pack
    import ctx_pkg::*;
#(
    parameter int SEGBITS     = 40,
    parameter bit COMPAT_ONLY = 1'b0
) (
    input  logic [REG_W-1:0] vaddr,
    input  logic [POS_W-1:0] top_x,
    input  logic [POS_W-1:0] bot_y,
    output logic [REG_W-1:0] base_m,
    output logic [REG_W-1:0] region_m,
    output logic [REG_W-1:0] vpn_m,
    output logic [REG_W-1:0] region_v,
    output logic [REG_W-1:0] vpn_v
);
    localparam logic [POS_W-1:0] SEG_P = POS_W'(SEGBITS);

    logic [POS_W-1:0] win_w;
    logic [POS_W-1:0] shamt;
    logic [1:0]       rcode;

    generate
        if (COMPAT_ONLY) begin : g_rcompat
            assign rcode = {vaddr[REG_W-1], vaddr[REG_W-1]};
        end else begin : g_rfull
            assign rcode = vaddr[REG_W-1:REG_W-2];
        end
    endgenerate

    always_comb begin
        win_w    = top_x - bot_y;
        shamt    = (win_w <= SEG_P) ? (SEG_P - win_w) : '0;
        base_m   = ~low_ones(top_x + POS_W'(2));
        region_m = low_ones(top_x + POS_W'(2)) & ~low_ones(top_x);
        vpn_m    = low_ones(top_x) & ~low_ones(bot_y);
        region_v = {{(REG_W-2){1'b0}}, rcode} << top_x;
        vpn_v    = (((vaddr & low_ones(SEG_P)) >> shamt) & low_ones(win_w)) << bot_y;
    end
endmodule

// File: rtl/ctx_pointer_reg.sv
module ctx_pointer_reg
    import ctx_pkg::*;
#(
    parameter int SEGBITS     = 40,
    parameter bit COMPAT_ONLY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [63:0]      sw_wdata,
    input  logic             exc_valid,
    input  logic [2:0]       exc_cause,
    input  logic [63:0]      exc_vaddr,
    input  logic             layout_var,
    input  logic [63:0]      cfg_mask,
    output logic [63:0]      ctx_q
);
    localparam logic [POS_W-1:0] FIX_X = POS_W'(SEGBITS - 9);
    localparam logic [POS_W-1:0] FIX_Y = POS_W'(4);
    localparam logic [REG_W-1:0] FIX_MASK = low_ones(FIX_X) & ~low_ones(FIX_Y);

    logic [REG_W-1:0] eff_mask;
    logic [POS_W-1:0] top_x, bot_y;
    logic [REG_W-1:0] base_m, region_m, vpn_m, region_v, vpn_v;
    logic             hw_upd;
    logic [REG_W-1:0] ctx_n;

    assign eff_mask = layout_var ? cfg_mask : FIX_MASK;

    ctx_mask_decode #(.WIDTH(REG_W)) u_dec (
        .mask  (eff_mask),
        .top_x (top_x),
        .bot_y (bot_y)
    );

    ctx_field_pack #(.SEGBITS(SEGBITS), .COMPAT_ONLY(COMPAT_ONLY)) u_pack (
        .vaddr    (exc_vaddr),
        .top_x    (top_x),
        .bot_y    (bot_y),
        .base_m   (base_m),
        .region_m (region_m),
        .vpn_m    (vpn_m),
        .region_v (region_v),
        .vpn_v    (vpn_v)
    );

    always_comb begin
        hw_upd = 1'b0;
        if (exc_valid) begin
            unique case (exc_cause)
                CAUSE_REFILL, CAUSE_INVALID, CAUSE_MODIFIED: hw_upd = 1'b1;
                default:                                     hw_upd = 1'b0;
            endcase
        end
    end

    always_comb begin
        ctx_n = ctx_q;
        if (sw_we) ctx_n = (ctx_n & ~base_m) | (sw_wdata & base_m);
        if (hw_upd) ctx_n = (ctx_n & ~(region_m | vpn_m)) | region_v | vpn_v;
        if (sw_we || hw_upd) ctx_n = ctx_n & (base_m | region_m | vpn_m);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_n;
    end

    logic qual_exc;
    assign qual_exc = exc_valid && (exc_cause <= 3'd2);

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !qual_exc) |=> $stable(ctx_q));

    assert_addr_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && exc_valid && exc_cause == 3'd3) |=> $stable(ctx_q));

    assert_fixed_vpn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!layout_var && qual_exc) |=>
            ctx_q[SEGBITS-10:4] == $past(exc_vaddr[SEGBITS-1:13]));

    assert_fixed_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!layout_var && (sw_we || qual_exc)) |=> ctx_q[3:0] == 4'd0);

    assert_fixed_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!layout_var && sw_we) |=>
            ctx_q[63:SEGBITS-7] == $past(sw_wdata[63:SEGBITS-7]));

    assert_fixed_keep_hw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!layout_var && sw_we && !qual_exc) |=>
            ctx_q[SEGBITS-8:4] == $past(ctx_q[SEGBITS-8:4]));

    generate
        if (!COMPAT_ONLY) begin : g_chk_region
            assert_fixed_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!layout_var && qual_exc) |=>
                    ctx_q[SEGBITS-8:SEGBITS-9] == $past(exc_vaddr[63:62]));
        end else begin : g_chk_compat
            assert_compat_region_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (!layout_var && qual_exc) |=>
                    ctx_q[SEGBITS-8] == ctx_q[SEGBITS-9]);
        end
    endgenerate
endmodule

// File: tb/tb_ctx_pointer_reg.sv
`timescale 1ns/1ps
module tb_ctx_pointer_reg;
    localparam int SEGBITS = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [63:0] sw_wdata = '0;
    logic        exc_valid = 1'b0;
    logic [2:0]  exc_cause = '0;
    logic [63:0] exc_vaddr = '0;
    logic        layout_var = 1'b0;
    logic [63:0] cfg_mask = '0;
    logic [63:0] ctx_q, ctx_c;

    always #4 clk = ~clk;

    ctx_pointer_reg #(.SEGBITS(SEGBITS), .COMPAT_ONLY(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_vaddr(exc_vaddr),
        .layout_var(layout_var), .cfg_mask(cfg_mask), .ctx_q(ctx_q));

    ctx_pointer_reg #(.SEGBITS(SEGBITS), .COMPAT_ONLY(1'b1)) dut_c (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_vaddr(exc_vaddr),
        .layout_var(layout_var), .cfg_mask(cfg_mask), .ctx_q(ctx_c));

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R1";
    string chk_req = "R1";
    logic [63:0] exp_q = '0;
    logic [63:0] exp_c = '0;

    // Behavioural model: bit-by-bit ownership from the requirements.
    function automatic logic [63:0] model_next(
        input logic [63:0] old, input logic we, input logic [63:0] wd,
        input logic ev, input logic [2:0] cause, input logic [63:0] va,
        input logic vmode, input logic [63:0] mask, input bit compat);
        int x, y;
        logic hw;
        logic [1:0] rc;
        logic [63:0] r;
        hw = ev && (cause == 3'd0 || cause == 3'd1 || cause == 3'd2);
        if (!vmode) begin
            x = SEGBITS - 9; y = 4;
        end else begin
            x = 0; y = 0;
            for (int i = 0; i < 64; i++) if (mask[i]) x = i + 1;
            for (int i = 63; i >= 0; i--) if (mask[i]) y = i;
        end
        rc = compat ? {va[63], va[63]} : va[63:62];
        r = old;
        for (int b = 0; b < 64; b++) begin
            if (b >= x + 2) begin
                if (we) r[b] = wd[b];
            end else if (b >= x) begin
                if (hw) r[b] = (b == x) ? rc[0] : rc[1];
            end else if (b >= y) begin
                if (hw) r[b] = va[SEGBITS - x + b];
            end else begin
                if (we || hw) r[b] = 1'b0;
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        chk_req <= cur_req;
        if (!rst_n) begin
            exp_q <= '0;
            exp_c <= '0;
        end else begin
            exp_q <= model_next(exp_q, sw_we, sw_wdata, exc_valid, exc_cause,
                                exc_vaddr, layout_var, cfg_mask, 1'b0);
            exp_c <= model_next(exp_c, sw_we, sw_wdata, exc_valid, exc_cause,
                                exc_vaddr, layout_var, cfg_mask, 1'b1);
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(chk_req, ctx_q, exp_q);
            check({chk_req, " R10"}, ctx_c, exp_c);
        end
    end

    task automatic drive(input logic we, input logic [63:0] wd, input logic ev,
                         input logic [2:0] cause, input logic [63:0] va, input string req);
        @(negedge clk);
        sw_we = we; sw_wdata = wd; exc_valid = ev; exc_cause = cause; exc_vaddr = va;
        cur_req = req;
    endtask

    task automatic idle(input string req);
        drive(1'b0, 64'h0, 1'b0, 3'd0, 64'h0, req);
    endtask

    task automatic set_cfg(input logic vmode, input logic [63:0] m);
        @(negedge clk);
        sw_we = 1'b0; exc_valid = 1'b0; layout_var = vmode; cfg_mask = m;
        cur_req = "R11";
    endtask

    function automatic logic [63:0] run_mask(input int hi, input int lo);
        logic [63:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    logic [63:0] fixed_val;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", ctx_q, 64'h0);

        // fixed layout
        drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 3'd0, 64'h0, "R4");
        drive(1, 64'hA5A5_0000_0000_000F, 1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
        drive(0, 64'h0, 1, 3'd1, 64'h5555_5555_5555_5555, "R2");
        drive(0, 64'h0, 1, 3'd2, 64'h8000_00AA_AAAA_A000, "R3");
        drive(0, 64'h0, 1, 3'd0, 64'h4000_0012_3456_7000, "R3");
        drive(1, 64'h1234_5678_FFFF_FFFF, 0, 3'd0, 64'h0, "R4");
        drive(0, 64'h0, 1, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        drive(0, 64'h0, 1, 3'd5, 64'h0, "R8");
        drive(0, 64'h0, 1, 3'd7, 64'hC000_0000_0000_0000, "R8");
        idle("R11");
        idle("R11");
        for (int i = 13; i < SEGBITS; i += 5)
            drive(0, 64'h0, 1, 3'd0, (64'd1 << i) | 64'hC000_0000_0000_0000, "R2");
        drive(1, 64'hDEAD_BEEF_0000_0000, 1, 3'd2, 64'hC000_00F0_F0F0_F000, "R9");
        idle("R5");
        check("R5", {60'h0, ctx_q[3:0]}, 64'h0);
        fixed_val = ctx_q;

        // variable layout matching the fixed one
        set_cfg(1'b1, run_mask(30, 4));
        drive(1, 64'h0, 0, 3'd0, 64'h0, "R7");
        drive(1, 64'hDEAD_BEEF_0000_0000, 1, 3'd2, 64'hC000_00F0_F0F0_F000, "R7");
        idle("R7");
        check("R7", ctx_q, fixed_val);

        // narrow window 20..8
        set_cfg(1'b1, run_mask(20, 8));
        drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 3'd0, 64'h0, "R4");
        drive(0, 64'h0, 1, 3'd0, 64'h4000_00AB_C000_0000, "R6");
        drive(0, 64'h0, 1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        drive(1, 64'h0, 0, 3'd0, 64'h0, "R4");
        drive(0, 64'h0, 1, 3'd3, 64'h0, "R8");

        // mid window 45..20
        set_cfg(1'b1, run_mask(45, 20));
        drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd2, 64'h8000_0055_5555_5000, "R9");
        drive(0, 64'h0, 1, 3'd0, 64'h3FFF_FF12_3456_7000, "R6");
        idle("R11");

        // top window 61..40: region at 63..62, no base bits
        set_cfg(1'b1, run_mask(61, 40));
        drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 3'd0, 64'h0, "R4");
        drive(0, 64'h0, 1, 3'd0, 64'h8000_00FE_DCBA_0000, "R3");
        drive(0, 64'h0, 1, 3'd1, 64'h4000_0001_2345_0000, "R6");
        idle("R11");

        // compat region codes in fixed layout
        set_cfg(1'b0, 64'h0);
        drive(0, 64'h0, 1, 3'd0, 64'h8000_0000_0000_0000, "R10");
        drive(0, 64'h0, 1, 3'd0, 64'h4000_0000_0000_0000, "R10");
        idle("R10");

        // reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", ctx_q, 64'h0);
        idle("R11");
        idle("R11");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule